// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory of 256 words by 18 bits, split into two 9-bit byte lanes. The address and the command are taken on a rising clock edge. The data for that command, read or write, belongs to the bus cycle two clocks later. Because write data sits in the same delayed slot as read data, reads and writes can follow each other on every clock with no idle bus cycle between them.

A load/advance input either starts a new access at an external address or continues the current one. To continue, an internal 2-bit burst counter steps, giving four words per address in linear or interleaved order. An active-low clock enable freezes the whole block. Three chip enables gate new accesses but never cancel accesses already in flight. An asynchronous output enable can switch off the bus driver at any time. The bidirectional bus is modelled as separate data-in, data-out and drive-enable signals.

Top module: `pipe_sram`

## Requirements
- R1: A command taken at the rising edge that ends cycle n has its data in cycle n+2. For a read, `dOut` holds the word and `dDrive` is 1 throughout cycle n+2. For a write, `dIn` is taken at the edge that ends cycle n+2.
- R2: A command is accepted on every clock edge, and any mix of reads and writes runs back to back with no idle cycle.
- R3: While `clkEnB` is 1, every input except `outEnN` is ignored, and all state holds its value: both pipeline stages, the burst state and `dOut`. Nothing is written to the array.
- R4: With `advance` = 0, a new access starts only when `chipSel0N` = 0, `chipSel1N` = 0 and `chipSel2` = 1. With any other combination, that cycle issues nothing.
- R5: A deselect does not cancel accesses that are already in the pipeline. Those accesses complete with their normal data cycle.
- R6: `dDrive` is 0 in the second cycle after a deselect or after a write command.
- R7: With `advance` = 1 and an active burst, the previous access type is repeated and the burst count steps by 1 modulo 4. After a deselect, `advance` = 1 starts nothing.
- R8: `orderLinear` is taken with the load. If it is 1, the low two address bits are the base bits plus the count, modulo 4. If it is 0, they are the base bits XOR the count. The upper address bits stay at the base.
- R9: `laneWrN[i]` = 0 enables lane i of a write, where lane 0 is bits 8:0 and lane 1 is bits 17:9. The lane selects are taken with the command. A lane that is not enabled keeps its old contents.
- R10: `outEnN` = 1 forces `dDrive` to 0 at once, without waiting for a clock edge, and does not disturb the pipeline.
- R11: A read that reaches the array in the same edge in which a write to that address is being completed returns the newly written lanes and the old contents of the other lanes.
- R12: After reset, both pipeline stages are idle, no burst is active and `dDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnB | input | 1 | Clock enable, active low; 1 freezes the block |
| chipSel0N | input | 1 | Chip enable, active low |
| chipSel1N | input | 1 | Chip enable, active low |
| chipSel2 | input | 1 | Chip enable, active high |
| isRead | input | 1 | 1 = read, 0 = write, taken with a load |
| advance | input | 1 | 0 = load new address, 1 = continue burst |
| orderLinear | input | 1 | 1 = linear burst order, 0 = interleaved |
| laneWrN | input | 2 | Per-lane write enables, active low |
| addr | input | 8 | Word address |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dIn | input | 18 | Write data, taken in the data cycle |
| dOut | output | 18 | Read data register |
| dDrive | output | 1 | Bus drive enable |

## Verification
Read data and `dDrive` are checked in the cycle two clocks after the read command. The bench applies inputs just after a falling edge and samples the outputs at the next falling edge, so that every check lands in the cycle the command's data is due. Write data is placed on `dIn` two calls of the cycle task after its command, and is proven by a later read whose result is again expected two cycles after that read. Stall cycles are checked by observing that `dOut` and `dDrive` stay frozen and that a write issued during the stall leaves no trace. The output-enable checks are made a nanosecond after `outEnN` changes, with no clock edge in between.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef struct packed {
    logic step;
    logic readNow;
    logic writeNow;
    logic forward;
  } sramStrobe_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnB,
  input  logic              chipSel0N,
  input  logic              chipSel1N,
  input  logic              chipSel2,
  input  logic              isRead,
  input  logic              advance,
  input  logic              orderLinear,
  input  logic [LANES-1:0]  laneWrN,
  input  logic [ADDR_W-1:0] addr,
  output sramStrobe_t       stb,
  output logic [ADDR_W-1:0] readAddr,
  output logic [ADDR_W-1:0] writeAddr,
  output logic [LANES-1:0]  writeMask,
  output logic              driveValid
);
  localparam int HI_W = ADDR_W - 2;

  logic              burstActive, burstRead, burstLinear;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        cnt;
  logic              s1Valid, s1Read, s2Valid, s2Read;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1MaskN, s2MaskN;

  logic              step, allSel, loadCmd, advCmd, issueValid, issueRead, issueLinear;
  logic [1:0]        nextCnt, issueLow;
  logic [ADDR_W-1:0] issueBase, issueAddr;

  always_comb begin
    step        = !clkEnB;
    allSel      = !chipSel0N && !chipSel1N && chipSel2;
    loadCmd     = !advance && allSel;
    advCmd      = advance && burstActive;
    issueValid  = loadCmd || advCmd;
    issueRead   = loadCmd ? isRead : burstRead;
    issueLinear = loadCmd ? orderLinear : burstLinear;
    issueBase   = loadCmd ? addr : baseAddr;
    nextCnt     = advCmd ? cnt + 2'd1 : 2'd0;
    issueLow    = issueLinear ? issueBase[1:0] + nextCnt : issueBase[1:0] ^ nextCnt;
    issueAddr   = {issueBase[ADDR_W-1 -: HI_W], issueLow};
  end

  // burst state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstRead   <= 1'b0;
      burstLinear <= 1'b0;
      baseAddr    <= '0;
      cnt         <= 2'd0;
    end else if (step) begin
      if (!advance) begin
        burstActive <= allSel;
        burstRead   <= isRead;
        burstLinear <= orderLinear;
        baseAddr    <= addr;
        cnt         <= 2'd0;
      end else if (burstActive) begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  // two-stage command pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Read  <= 1'b0;
      s1Addr  <= '0;
      s1MaskN <= '1;
      s2Valid <= 1'b0;
      s2Read  <= 1'b0;
      s2Addr  <= '0;
      s2MaskN <= '1;
    end else if (step) begin
      s1Valid <= issueValid;
      s1Read  <= issueRead;
      s1Addr  <= issueAddr;
      s1MaskN <= laneWrN;
      s2Valid <= s1Valid;
      s2Read  <= s1Read;
      s2Addr  <= s1Addr;
      s2MaskN <= s1MaskN;
    end
  end

  always_comb begin
    stb.step     = step;
    stb.readNow  = s1Valid && s1Read;
    stb.writeNow = s2Valid && !s2Read;
    stb.forward  = stb.readNow && stb.writeNow && (s1Addr == s2Addr);
    readAddr     = s1Addr;
    writeAddr    = s2Addr;
    writeMask    = ~s2MaskN;
    driveValid   = s2Valid && s2Read;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnB && !advance && allSel && isRead) |=> (s1Valid && s1Read && s1Addr == $past(addr)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    clkEnB |=> ($stable(s1Valid) && $stable(s2Valid) && $stable(s2Addr) && $stable(cnt)));

  assert_deselect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnB && !advance && !allSel) |=> !s1Valid);

  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnB && advance && burstActive) |=> (cnt == $past(cnt) + 2'd1));
endmodule

// File: rtl/pipe_sram_data.sv
module pipe_sram_data
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sramStrobe_t             stb,
  input  logic [ADDR_W-1:0]       readAddr,
  input  logic [ADDR_W-1:0]       writeAddr,
  input  logic [LANES-1:0]        writeMask,
  input  logic [LANE_W*LANES-1:0] dIn,
  output logic [LANE_W*LANES-1:0] dOut
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] rdLane;
    logic [LANE_W-1:0] inLane;

    assign inLane = dIn[i*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (stb.step && stb.writeNow && writeMask[i]) laneMem[writeAddr] <= inLane;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdLane <= '0;
      else if (stb.step && stb.readNow)
        rdLane <= (stb.forward && writeMask[i]) ? inLane : laneMem[readAddr];
    end

    assign dOut[i*LANE_W +: LANE_W] = rdLane;
  end

  assert_forward_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.forward |-> (stb.readNow && stb.writeNow && readAddr == writeAddr));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnB,
  input  logic              chipSel0N,
  input  logic              chipSel1N,
  input  logic              chipSel2,
  input  logic              isRead,
  input  logic              advance,
  input  logic              orderLinear,
  input  logic [LANES-1:0]  laneWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dDrive
);
  sramStrobe_t       stb;
  logic [ADDR_W-1:0] readAddr, writeAddr;
  logic [LANES-1:0]  writeMask;
  logic              driveValid;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnB(clkEnB),
    .chipSel0N(chipSel0N), .chipSel1N(chipSel1N), .chipSel2(chipSel2),
    .isRead(isRead), .advance(advance), .orderLinear(orderLinear),
    .laneWrN(laneWrN), .addr(addr), .stb(stb),
    .readAddr(readAddr), .writeAddr(writeAddr), .writeMask(writeMask),
    .driveValid(driveValid)
  );

  pipe_sram_data #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .readAddr(readAddr), .writeAddr(writeAddr), .writeMask(writeMask),
    .dIn(dIn), .dOut(dOut)
  );

  assign dDrive = driveValid && !outEnN;

  assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dDrive);
endmodule

// File: tb/tb_pipe_sram.sv
module tb_pipe_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnB = 1'b0;
  logic        chipSel0N = 1'b1, chipSel1N = 1'b1, chipSel2 = 1'b0;
  logic        isRead = 1'b0, advance = 1'b0, orderLinear = 1'b1;
  logic [1:0]  laneWrN = 2'b11;
  logic [7:0]  addr = '0;
  logic        outEnN = 1'b0;
  logic [17:0] dIn = '0;
  logic [17:0] dOut;
  logic        dDrive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pipe_sram dut (
    .clk(clk), .rstN(rstN), .clkEnB(clkEnB),
    .chipSel0N(chipSel0N), .chipSel1N(chipSel1N), .chipSel2(chipSel2),
    .isRead(isRead), .advance(advance), .orderLinear(orderLinear),
    .laneWrN(laneWrN), .addr(addr), .outEnN(outEnN),
    .dIn(dIn), .dOut(dOut), .dDrive(dDrive)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        rd;
    logic        adv;
    logic [2:0]  sel;   // {chipSel0N, chipSel1N, chipSel2}
    logic [7:0]  a;
    logic [1:0]  wrN;
    logic [17:0] din;
    logic        drv;
    logic [17:0] dat;
  } vec_t;

  // R2 R5 R6 R9 R11: mixed back-to-back traffic, one row per cycle
  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 3'b001, 8'h10, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, 1'b0, 3'b001, 8'h11, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 3'b001, 8'h10, 2'b00, 18'h12345, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 3'b001, 8'h11, 2'b00, 18'h0ABCD, 1'b0, 18'h00000},
    '{1'b0, 1'b0, 3'b001, 8'h11, 2'b10, 18'h00000, 1'b1, 18'h12345},
    '{1'b1, 1'b0, 3'b001, 8'h11, 2'b00, 18'h00000, 1'b1, 18'h0ABCD},
    '{1'b0, 1'b0, 3'b000, 8'h00, 2'b11, 18'h3FFFF, 1'b0, 18'h00000},
    '{1'b0, 1'b0, 3'b000, 8'h00, 2'b11, 18'h00000, 1'b1, 18'h0ABFF},
    '{1'b0, 1'b0, 3'b000, 8'h00, 2'b11, 18'h00000, 1'b0, 18'h00000}
  };

  task automatic setIn(input logic rd, input logic adv, input logic [2:0] sel,
                       input logic lin, input logic [7:0] a, input logic [1:0] wrN,
                       input logic [17:0] din);
    isRead = rd; advance = adv; orderLinear = lin; addr = a; laneWrN = wrN; dIn = din;
    {chipSel0N, chipSel1N, chipSel2} = sel;
  endtask

  task automatic cyc(input logic rd, input logic adv, input logic [2:0] sel,
                     input logic lin, input logic [7:0] a, input logic [1:0] wrN,
                     input logic [17:0] din);
    setIn(rd, adv, sel, lin, a, wrN, din);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [17:0] din);
    cyc(1'b0, 1'b0, 3'b000, 1'b1, 8'h00, 2'b11, din);
  endtask

  task automatic chk(input string tag, input logic expDrv, input logic [17:0] expDat);
    checks++;
    if (dDrive !== expDrv || (expDrv && dOut !== expDat)) begin
      errors++;
      $display("FAIL %s: actual drive=%b data=%h expected drive=%b data=%h",
               tag, dDrive, dOut, expDrv, expDat);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 during reset", 1'b0, 18'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 after reset", 1'b0, 18'h0);

    // vector table walk
    for (int i = 0; i < 9; i++) begin
      setIn(VEC[i].rd, VEC[i].adv, VEC[i].sel, 1'b1, VEC[i].a, VEC[i].wrN, VEC[i].din);
      #1;
      chk($sformatf("R1 R2 R5 R6 R9 R11 vector %0d", i), VEC[i].drv, VEC[i].dat);
      @(posedge clk);
      @(negedge clk);
    end

    // R7 R8: linear write burst from 0x21 -> 21,22,23,20
    cyc(1'b0, 1'b0, 3'b001, 1'b1, 8'h21, 2'b00, 18'h0);
    cyc(1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 2'b00, 18'h0);
    cyc(1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 2'b00, 18'h00111);
    cyc(1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 2'b00, 18'h00222);
    idle(18'h00333);
    idle(18'h00444);

    // R8: interleaved read from 0x22 -> 22,23,20,21
    cyc(1'b1, 1'b0, 3'b001, 1'b0, 8'h22, 2'b11, 18'h0);
    cyc(1'b0, 1'b1, 3'b000, 1'b1, 8'h00, 2'b11, 18'h0);
    chk("R8 interleaved word0", 1'b1, 18'h00222);
    cyc(1'b0, 1'b1, 3'b000, 1'b1, 8'h00, 2'b11, 18'h0);
    chk("R8 interleaved word1", 1'b1, 18'h00333);
    cyc(1'b0, 1'b1, 3'b000, 1'b1, 8'h00, 2'b11, 18'h0);
    chk("R8 interleaved word2", 1'b1, 18'h00444);
    idle(18'h0);
    chk("R7 interleaved word3", 1'b1, 18'h00111);
    idle(18'h0);
    chk("R6 drive off after deselect", 1'b0, 18'h0);

    // R8: linear read from 0x23 -> 23,20,21,22
    cyc(1'b1, 1'b0, 3'b001, 1'b1, 8'h23, 2'b11, 18'h0);
    cyc(1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 2'b11, 18'h0);
    chk("R8 linear word0", 1'b1, 18'h00333);
    cyc(1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 2'b11, 18'h0);
    chk("R8 linear word1", 1'b1, 18'h00444);
    cyc(1'b0, 1'b1, 3'b000, 1'b0, 8'h00, 2'b11, 18'h0);
    chk("R8 linear word2", 1'b1, 18'h00111);
    idle(18'h0);
    chk("R7 linear word3", 1'b1, 18'h00222);
    idle(18'h0);

    // R3: stall freezes outputs and ignores a write
    cyc(1'b1, 1'b0, 3'b001, 1'b1, 8'h22, 2'b11, 18'h0);
    idle(18'h0);
    chk("R3 before stall", 1'b1, 18'h00222);
    clkEnB = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 3'b001, 1'b1, 8'h22, 2'b00, 18'h3FFFF);
      chk($sformatf("R3 stall hold %0d", k), 1'b1, 18'h00222);
    end
    clkEnB = 1'b0;
    idle(18'h3FFFF);
    chk("R3 resume drains", 1'b0, 18'h0);
    cyc(1'b1, 1'b0, 3'b001, 1'b1, 8'h22, 2'b11, 18'h0);
    idle(18'h3FFFF);
    chk("R3 stalled write ignored", 1'b1, 18'h00222);
    idle(18'h0);

    // R7: advance with no active burst starts nothing
    cyc(1'b1, 1'b1, 3'b001, 1'b1, 8'h22, 2'b11, 18'h0);
    idle(18'h0);
    chk("R7 advance without burst", 1'b0, 18'h0);

    // R4: each chip enable on its own blocks a load
    for (int s = 0; s < 3; s++) begin
      logic [2:0] bad;
      bad = (s == 0) ? 3'b101 : (s == 1) ? 3'b011 : 3'b000;
      cyc(1'b1, 1'b0, bad, 1'b1, 8'h22, 2'b11, 18'h0);
      idle(18'h0);
      chk($sformatf("R4 enable combo %b", bad), 1'b0, 18'h0);
    end

    // R10: asynchronous output enable
    cyc(1'b1, 1'b0, 3'b001, 1'b1, 8'h10, 2'b11, 18'h0);
    idle(18'h0);
    chk("R10 driving with enable", 1'b1, 18'h12345);
    outEnN = 1'b1;
    #1;
    chk("R10 forced off", 1'b0, 18'h0);
    outEnN = 1'b0;
    #1;
    chk("R10 restored", 1'b1, 18'h12345);
    idle(18'h0);
    idle(18'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule